// File: doc/BRIEF.md
# Extender-Fed Ripple ALU

This block is a purely combinational arithmetic-logic unit of parameterised width. A single chain of full adders produces every result. A row of per-bit operand extenders sits in front of that chain. The extenders rewrite the two adder operands and the carry-in according to a mode bit and a two-bit operation select.

In arithmetic mode the extenders pass A through unchanged. They present B, its bitwise complement, all zeros or all ones as the second operand, and set the carry-in where the operation needs it. In logic mode the bitwise logic result is formed in the extender and routed through the first adder operand. The second operand and the carry-in are held at zero, so the chain passes that value straight to the output.

The block has no states, clock or storage. The enumerated operation codes take the place that state names take in a sequential design.

Top module: `opext_alu`

## Requirements
- R1: With `mode`=0 and `sel`=2'b00 (invert), `result` is the bitwise complement of `op_a`.
- R2: With `mode`=0 and `sel`=2'b01 (and), `result` is `op_a` AND `op_b`, bit by bit.
- R3: With `mode`=0 and `sel`=2'b10 (pass), `result` equals `op_a`.
- R4: With `mode`=0 and `sel`=2'b11 (or), `result` is `op_a` OR `op_b`, bit by bit.
- R5: With `mode`=1 and `sel`=2'b00 (add), {`carry_out`,`result`} equals the unsigned sum `op_a`+`op_b`.
- R6: With `mode`=1 and `sel`=2'b01 (subtract), `result` is `op_a`−`op_b` modulo 2^WIDTH. `carry_out` is 1 exactly when `op_a` ≥ `op_b` unsigned, because the subtraction is formed as A + ~B + 1.
- R7: With `mode`=1 and `sel`=2'b10 (increment), `result` is `op_a`+1 modulo 2^WIDTH. `carry_out` is 1 only when `op_a` is all ones.
- R8: With `mode`=1 and `sel`=2'b11 (decrement), `result` is `op_a`−1 modulo 2^WIDTH. `carry_out` is 0 only when `op_a` is zero.
- R9: In arithmetic mode, `overflow` is 1 exactly when the two's-complement result of the selected operation falls outside the signed WIDTH-bit range. This equals the XOR of the carries into and out of the most significant bit.
- R10: In logic mode, `carry_out` and `overflow` are 0. For invert and pass, `result` does not depend on `op_b`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| mode | input | 1 | 0 = logic operations, 1 = arithmetic operations |
| sel | input | 2 | Operation select within the chosen mode |
| result | output | WIDTH | Operation result |
| carry_out | output | 1 | Carry from the most significant full adder; 0 in logic mode |
| overflow | output | 1 | Signed overflow in arithmetic mode; 0 in logic mode |

## Verification
Every output is a combinational function of the present inputs, so each result is due in the same clock cycle as its stimulus, with no register delay. The bench drives a vector 1 ns after a rising edge and queues its expected outputs. It pops and compares them at the following falling edge, which keeps exactly one vector in flight and samples after the ripple chain has settled. All eight operations are swept exhaustively over both operands at the default width. This covers the wrap, borrow and signed-range corners of R6 to R9, and the independence from `op_b` required by R10.

// File: rtl/opext_pkg.sv
package opext_pkg;

    localparam logic MODE_LOGIC = 1'b0;
    localparam logic MODE_ARITH = 1'b1;

    typedef enum logic [1:0] {
        LG_INV  = 2'b00,
        LG_AND  = 2'b01,
        LG_PASS = 2'b10,
        LG_OR   = 2'b11
    } lg_op_e;

    typedef enum logic [1:0] {
        AR_ADD = 2'b00,
        AR_SUB = 2'b01,
        AR_INC = 2'b10,
        AR_DEC = 2'b11
    } ar_op_e;

    typedef struct packed {
        logic opx;
        logic opy;
    } ext_bit_t;

    // Rewrite one operand bit pair for the adder input.
    function automatic ext_bit_t ext_bit(input logic a, input logic b,
                                         input logic mode, input logic [1:0] sel);
        ext_bit_t r;
        r.opx = 1'b0;
        r.opy = 1'b0;
        if (mode == MODE_ARITH) begin
            r.opx = a;
            unique case (ar_op_e'(sel))
                AR_ADD: r.opy = b;
                AR_SUB: r.opy = ~b;
                AR_INC: r.opy = 1'b0;
                AR_DEC: r.opy = 1'b1;
            endcase
        end else begin
            r.opy = 1'b0;
            unique case (lg_op_e'(sel))
                LG_INV:  r.opx = ~a;
                LG_AND:  r.opx = a & b;
                LG_PASS: r.opx = a;
                LG_OR:   r.opx = a | b;
            endcase
        end
        return r;
    endfunction

    // Carry-in for the chain: set for subtract and increment only.
    function automatic logic ext_carry(input logic mode, input logic [1:0] sel);
        logic c;
        c = 1'b0;
        if (mode == MODE_ARITH) begin
            unique case (ar_op_e'(sel))
                AR_ADD: c = 1'b0;
                AR_SUB: c = 1'b1;
                AR_INC: c = 1'b1;
                AR_DEC: c = 1'b0;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/opext_extender.sv
module opext_extender #(
    parameter int WIDTH = 5
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             mode_in,
    input  logic [1:0]       sel_in,
    output logic [WIDTH-1:0] x_out,
    output logic [WIDTH-1:0] y_out,
    output logic             cin_out
);
    import opext_pkg::*;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        ext_bit_t pair;
        always_comb begin
            pair     = ext_bit(a_in[i], b_in[i], mode_in, sel_in);
            x_out[i] = pair.opx;
            y_out[i] = pair.opy;
        end
    end

    always_comb begin
        cin_out = ext_carry(mode_in, sel_in);
    end

endmodule

// File: rtl/opext_full_adder.sv
module opext_full_adder (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    logic half;

    always_comb begin
        half = x ^ y;
        s    = half ^ ci;
        co   = (x & y) | (ci & half);
    end

endmodule

// File: rtl/opext_ripple.sv
module opext_ripple #(
    parameter int WIDTH = 5
) (
    input  logic [WIDTH-1:0] x_in,
    input  logic [WIDTH-1:0] y_in,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             c_msb_in,
    output logic             c_msb_out
);
    localparam int TOP = WIDTH - 1;

    logic [WIDTH:0] chain;

    assign chain[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_fa
        opext_full_adder u_fa (
            .x  (x_in[i]),
            .y  (y_in[i]),
            .ci (chain[i]),
            .s  (sum[i]),
            .co (chain[i+1])
        );
    end

    assign c_msb_in  = chain[TOP];
    assign c_msb_out = chain[WIDTH];

endmodule

// File: rtl/opext_alu.sv
module opext_alu #(
    parameter int WIDTH = 5
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             mode,
    input  logic [1:0]       sel,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             overflow
);
    import opext_pkg::*;

    logic [WIDTH-1:0] add_x;
    logic [WIDTH-1:0] add_y;
    logic             add_cin;
    logic             msb_cin;
    logic             msb_cout;

    opext_extender #(.WIDTH(WIDTH)) u_ext (
        .a_in    (op_a),
        .b_in    (op_b),
        .mode_in (mode),
        .sel_in  (sel),
        .x_out   (add_x),
        .y_out   (add_y),
        .cin_out (add_cin)
    );

    opext_ripple #(.WIDTH(WIDTH)) u_rca (
        .x_in      (add_x),
        .y_in      (add_y),
        .cin       (add_cin),
        .sum       (result),
        .c_msb_in  (msb_cin),
        .c_msb_out (msb_cout)
    );

    always_comb begin
        carry_out = (mode == MODE_ARITH) & msb_cout;
        overflow  = (mode == MODE_ARITH) & (msb_cin ^ msb_cout);
    end

endmodule

// File: rtl/opext_alu_chk.sv
module opext_alu_chk #(
    parameter int W = 5
) (
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic         mode_i,
    input logic [1:0]   sel_i,
    input logic [W-1:0] f_o,
    input logic         cout_o,
    input logic         ovf_o
);
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ONES = '1;
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
    localparam int           MSB  = W - 1;

    always_comb begin
        AST_LOGIC_INV: assert (mode_i || sel_i != 2'b00 || f_o == ~a_i) else $error("invert"); // R1
        AST_LOGIC_AND: assert (mode_i || sel_i != 2'b01 || f_o == (a_i & b_i)) else $error("and"); // R2
        AST_LOGIC_PASS: assert (mode_i || sel_i != 2'b10 || f_o == a_i) else $error("pass"); // R3
        AST_LOGIC_OR: assert (mode_i || sel_i != 2'b11 || f_o == (a_i | b_i)) else $error("or"); // R4
        AST_ARITH_ADD: assert (!mode_i || sel_i != 2'b00
                               || {cout_o, f_o} == ({1'b0, a_i} + {1'b0, b_i})) else $error("add"); // R5
        AST_ARITH_SUB: assert (!mode_i || sel_i != 2'b01
                               || (f_o == a_i - b_i && cout_o == (a_i >= b_i))) else $error("sub"); // R6
        AST_ARITH_INC: assert (!mode_i || sel_i != 2'b10
                               || (f_o == a_i + ONE && cout_o == (a_i == ONES))) else $error("inc"); // R7
        AST_ARITH_DEC: assert (!mode_i || sel_i != 2'b11
                               || (f_o == a_i - ONE && cout_o == (a_i != '0))) else $error("dec"); // R8
        AST_ADD_OVERFLOW: assert (!mode_i || sel_i != 2'b00
                                  || ovf_o == (a_i[MSB] == b_i[MSB] && f_o[MSB] != a_i[MSB])) else $error("ovf add"); // R9
        AST_SUB_OVERFLOW: assert (!mode_i || sel_i != 2'b01
                                  || ovf_o == (a_i[MSB] != b_i[MSB] && f_o[MSB] != a_i[MSB])) else $error("ovf sub"); // R9
        AST_STEP_OVERFLOW: assert (!mode_i || sel_i[1] != 1'b1
                                   || ovf_o == (sel_i[0] ? (a_i == SMIN) : (a_i == SMAX))) else $error("ovf step"); // R9
        AST_NO_LOGIC_FLAGS: assert (mode_i || (!cout_o && !ovf_o)) else $error("logic flags"); // R10
    end

endmodule

bind opext_alu opext_alu_chk #(.W(WIDTH)) u_chk (
    .a_i    (op_a),
    .b_i    (op_b),
    .mode_i (mode),
    .sel_i  (sel),
    .f_o    (result),
    .cout_o (carry_out),
    .ovf_o  (overflow)
);

// File: tb/opext_alu_bench.sv
module opext_alu_bench;
    localparam int W    = 5;
    localparam int SPAN = 1 << W;
    localparam int MASK = SPAN - 1;
    localparam int HALF = SPAN / 2;

    typedef struct {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         m;
        logic [1:0]   s;
        logic [W-1:0] f;
        logic         co;
        logic         ov;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         mode = 1'b0;
    logic [1:0]   sel = 2'b00;
    logic [W-1:0] result;
    logic         carry_out;
    logic         overflow;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    opext_alu #(.WIDTH(W)) u_opext_alu (
        .op_a      (op_a),
        .op_b      (op_b),
        .mode      (mode),
        .sel       (sel),
        .result    (result),
        .carry_out (carry_out),
        .overflow  (overflow)
    );

    function automatic string op_tag(input logic m, input logic [1:0] s);
        case ({m, s})
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b010:  return "R3";
            3'b011:  return "R4";
            3'b100:  return "R5";
            3'b101:  return "R6";
            3'b110:  return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic exp_t model(input int a, input int b, input logic m, input logic [1:0] s);
        exp_t e;
        int   sum;
        int   sa;
        int   sb;
        int   sres;
        e.a = W'(a);
        e.b = W'(b);
        e.m = m;
        e.s = s;
        sa  = (a >= HALF) ? a - SPAN : a;
        sb  = (b >= HALF) ? b - SPAN : b;
        if (!m) begin
            case (s)
                2'b00:   sum = (~a) & MASK;
                2'b01:   sum = a & b;
                2'b10:   sum = a;
                default: sum = a | b;
            endcase
            e.f  = W'(sum);
            e.co = 1'b0;
            e.ov = 1'b0;
        end else begin
            case (s)
                2'b00:   begin sum = a + b;                sres = sa + sb; end
                2'b01:   begin sum = a + ((~b) & MASK) + 1; sres = sa - sb; end
                2'b10:   begin sum = a + 1;                sres = sa + 1;  end
                default: begin sum = a + MASK;             sres = sa - 1;  end
            endcase
            e.f  = W'(sum & MASK);
            e.co = ((sum >> W) & 1) != 0;
            e.ov = (sres > HALF - 1) || (sres < -HALF);
        end
        return e;
    endfunction

    task automatic drive(input int a, input int b, input logic m, input logic [1:0] s);
        @(posedge clk);
        #1;
        op_a = W'(a);
        op_b = W'(b);
        mode = m;
        sel  = s;
        sb_q.push_back(model(a, b, m, s));
    endtask

    // Monitor: results are combinational, compared at the falling edge.
    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_tests++;
            if (result !== e.f) begin
                n_fail++;
                $display("FAIL %s a=%h b=%h result=%h expected=%h", op_tag(e.m, e.s), e.a, e.b, result, e.f);
            end
            n_tests++;
            if (carry_out !== e.co) begin
                n_fail++;
                $display("FAIL %s a=%h b=%h carry_out=%b expected=%b",
                         e.m ? op_tag(e.m, e.s) : "R10", e.a, e.b, carry_out, e.co);
            end
            n_tests++;
            if (overflow !== e.ov) begin
                n_fail++;
                $display("FAIL %s a=%h b=%h overflow=%b expected=%b",
                         e.m ? "R9" : "R10", e.a, e.b, overflow, e.ov);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // Reset-time inputs are zero, invert selected: all ones (R1)
        n_tests++;
        if (result !== '1 || carry_out !== 1'b0 || overflow !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset result=%h expected=%h", result, {W{1'b1}});
        end
        rst_n = 1'b1;
        // Corner vectors named by requirement
        drive(MASK, 1, 1'b1, 2'b00);         // R5 wrap with carry
        drive(HALF - 1, 1, 1'b1, 2'b00);     // R9 positive overflow on add
        drive(0, 1, 1'b1, 2'b01);            // R6 borrow, carry 0
        drive(HALF, 1, 1'b1, 2'b01);         // R9 negative overflow on sub
        drive(MASK, 0, 1'b1, 2'b10);         // R7 increment wraps
        drive(HALF - 1, 0, 1'b1, 2'b10);     // R9 increment overflow
        drive(0, 0, 1'b1, 2'b11);            // R8 decrement of zero
        drive(HALF, 0, 1'b1, 2'b11);         // R9 decrement overflow
        drive(5, MASK, 1'b0, 2'b10);         // R10 pass ignores op_b
        // Exhaustive sweep of every operation
        for (int op = 0; op < 8; op++) begin
            for (int a = 0; a < SPAN; a++) begin
                for (int b = 0; b < SPAN; b++) begin
                    drive(a, b, op[2], op[1:0]);
                end
            end
        end
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired, queue=%0d expected=0", sb_q.size());
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule